// File: doc/BRIEF.md
# Pin-Level Serial Scan Chain

This block adds a board-test path to a memory device that has no spare pins. A dedicated scan-enable input moves the device into a sticky scan mode. In that mode four pins that normally serve the core take new roles: a shift/capture select, a scan clock, an active-low output enable and a serial output. Every signal pin under test has exactly one scan cell behind it. A capture loads all cells in parallel from their pins. Shift steps then walk the captured image out through the serial pad, one bit for each scan-clock rise. The cell at the head of the chain is fed a constant zero.

All logic runs on the core clock `clk`. The scan-clock pin is sampled on that clock, and one capture or shift happens on each detected low-to-high transition. Scan mode can only be left through `rst_n`, which stands in for a power cycle. While the device is in scan mode, the core-facing copies of the borrowed pins are held at their inactive levels. Pins wired to a reserved position always capture zero. The order of the cells is a fixed permutation of the pin indices: chain position k holds pin (k*ORDER_STRIDE + ORDER_OFFSET) mod NUM_PINS, and ORDER_STRIDE must be odd.

Top module: `pin_scan_chain`

## Requirements
- R1: Scan mode starts on the first `clk` rising edge that sees `scan_en_i` high, and `scan_mode_o` then reads 1. While in scan mode, `core_rst_o`=0, `core_sel_n_o`=1 and `core_cfg_o`=0, whatever the dual-use pins do.
- R2: While `scan_en_i` stays low, scan mode is never entered. In that state `core_rst_o`, `core_sel_n_o` and `core_cfg_o` follow `dual_rst_i`, `dual_sel_n_i` and `dual_cfg_i`. `scan_pad_o` carries `func_strobe_i` when `func_strobe_oe_i`=1 and is high-impedance otherwise.
- R3: Once entered, scan mode stays set after `scan_en_i` falls, and only `rst_n` low clears it.
- R4: The serial input of chain position 0 is logic 0. After a capture, every shift beyond NUM_PINS shifts presents 0 at the serial output.
- R5: A scan-clock event is a `clk` edge that sees `dual_sel_n_i`=1 after it was 0 on the previous edge, while in scan mode. If `dual_rst_i`=1, the event moves each cell one position toward position NUM_PINS-1. If `dual_rst_i`=0, the event loads every cell from its pin. Without such an event, the cells hold, even when `dual_rst_i` changes.
- R6: Chain positions that hold a pin whose bit in RSV_PINS is 1 (by default pins 1, 15 and 40) capture 0 whatever that pin's value is.
- R7: In scan mode, `scan_pad_o` drives chain position NUM_PINS-1 when `dual_cfg_i`=0, and is high-impedance when `dual_cfg_i`=1.
- R8: Chain position k captures pin (k*ORDER_STRIDE + ORDER_OFFSET) mod NUM_PINS; the defaults are 64, 5 and 3. After a capture, the pad shows position NUM_PINS-1, and the i-th shift exposes position NUM_PINS-1-i.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock; all state changes on its rising edge |
| rst_n | input | 1 | Active-low power-on reset; the only way out of scan mode |
| scan_en_i | input | 1 | Dedicated scan-enable pin |
| dual_rst_i | input | 1 | Dual-use pin: core reset normally, shift(1)/capture(0) select in scan mode |
| dual_sel_n_i | input | 1 | Dual-use pin: core select normally, scan clock in scan mode |
| dual_cfg_i | input | 1 | Dual-use pin: core config normally, active-low pad enable in scan mode |
| probe_i | input | NUM_PINS | Parallel values of the signal pins under test |
| func_strobe_i | input | 1 | Functional data for the shared output pad |
| func_strobe_oe_i | input | 1 | Functional drive enable for the shared output pad |
| core_rst_o | output | 1 | Core-facing copy of dual_rst_i (0 in scan mode) |
| core_sel_n_o | output | 1 | Core-facing copy of dual_sel_n_i (1 in scan mode) |
| core_cfg_o | output | 1 | Core-facing copy of dual_cfg_i (0 in scan mode) |
| scan_mode_o | output | 1 | Sticky scan-mode flag |
| scan_pad_o | output | 1 | Shared pad: serial scan result or functional strobe, tristate |

## Verification
A cell that captures from the wrong pin, or a reserved position that is not forced to zero, shows up as a wrong serial bit on the pad. The bit is wrong in exactly the shift slot that belongs to that position, so a single capture followed by NUM_PINS shifts exposes every such fault. A cell that does not hold, or that shifts twice for one scan-clock event, misaligns every later bit at once. A head input that is not zero shows up only in the trailing bits after position 0 has left the chain. A mode flag that is not sticky, or that is set too easily, shows at the very next sample as core-facing outputs that wrongly follow or wrongly ignore the dual-use pins.

// File: rtl/scan_pkg.sv
package scan_pkg;
  // Pin index held at a given chain position: a fixed permutation for odd stride.
  function automatic int unsigned chain_pin(input int unsigned pos,
                                            input int unsigned n_pins,
                                            input int unsigned stride,
                                            input int unsigned offset);
    return (pos * stride + offset) % n_pins;
  endfunction

  // Serial bit seen at the pad after a capture and `shifts` shift steps.
  function automatic int unsigned tail_pos(input int unsigned shifts,
                                           input int unsigned n_pins);
    return n_pins - 1 - shifts;
  endfunction
endpackage

// File: rtl/scan_mode_ctl.sv
module scan_mode_ctl (
  input  logic clk,
  input  logic rst_n,
  input  logic scan_en_i,
  input  logic dual_rst_i,
  input  logic dual_sel_n_i,
  input  logic dual_cfg_i,
  output logic scan_mode_o,
  output logic shift_evt_o,
  output logic capture_evt_o,
  output logic core_rst_o,
  output logic core_sel_n_o,
  output logic core_cfg_o
);
  logic mode_q;
  logic sclk_q;
  logic sclk_rise;

  // Sticky mode flag: only the power-on reset clears it.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_q <= 1'b0;
      sclk_q <= 1'b0;
    end else begin
      mode_q <= mode_q | scan_en_i;
      sclk_q <= dual_sel_n_i;
    end
  end

  assign sclk_rise     = mode_q & dual_sel_n_i & ~sclk_q;
  assign shift_evt_o   = sclk_rise & dual_rst_i;
  assign capture_evt_o = sclk_rise & ~dual_rst_i;
  assign scan_mode_o   = mode_q;

  // Borrowed pins are hidden from the core while scanning.
  assign core_rst_o   = mode_q ? 1'b0 : dual_rst_i;
  assign core_sel_n_o = mode_q ? 1'b1 : dual_sel_n_i;
  assign core_cfg_o   = mode_q ? 1'b0 : dual_cfg_i;
endmodule

// File: rtl/scan_cell_chain.sv
module scan_cell_chain
  import scan_pkg::*;
#(
  parameter int unsigned          NUM_PINS     = 64,
  parameter int unsigned          ORDER_STRIDE = 5,
  parameter int unsigned          ORDER_OFFSET = 3,
  parameter logic [NUM_PINS-1:0]  RSV_PINS     = 64'h0000_0100_0000_8002
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                shift_evt_i,
  input  logic                capture_evt_i,
  input  logic [NUM_PINS-1:0] probe_i,
  output logic [NUM_PINS-1:0] chain_q_o
);
  logic [NUM_PINS-1:0] cell_q;

  for (genvar k = 0; k < NUM_PINS; k++) begin : g_cell
    localparam int unsigned PIDX = chain_pin(k, NUM_PINS, ORDER_STRIDE, ORDER_OFFSET);
    logic ser_in;
    logic cap_in;

    if (k == 0) begin : g_head
      assign ser_in = 1'b0;
    end else begin : g_body
      assign ser_in = cell_q[k-1];
    end

    assign cap_in = probe_i[PIDX] & ~RSV_PINS[PIDX];

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)             cell_q[k] <= 1'b0;
      else if (capture_evt_i) cell_q[k] <= cap_in;
      else if (shift_evt_i)   cell_q[k] <= ser_in;
    end
  end

  assign chain_q_o = cell_q;
endmodule

// File: rtl/scan_out_drv.sv
module scan_out_drv (
  input  logic scan_mode_i,
  input  logic tail_i,
  input  logic scan_oe_n_i,
  input  logic func_data_i,
  input  logic func_oe_i,
  output logic drive_en_o,
  output logic drive_val_o
);
  assign drive_en_o  = scan_mode_i ? ~scan_oe_n_i : func_oe_i;
  assign drive_val_o = scan_mode_i ? tail_i : func_data_i;
endmodule

// File: rtl/pin_scan_chain.sv
module pin_scan_chain
  import scan_pkg::*;
#(
  parameter int unsigned          NUM_PINS     = 64,
  parameter int unsigned          ORDER_STRIDE = 5,
  parameter int unsigned          ORDER_OFFSET = 3,
  parameter logic [NUM_PINS-1:0]  RSV_PINS     = 64'h0000_0100_0000_8002
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                scan_en_i,
  input  logic                dual_rst_i,
  input  logic                dual_sel_n_i,
  input  logic                dual_cfg_i,
  input  logic [NUM_PINS-1:0] probe_i,
  input  logic                func_strobe_i,
  input  logic                func_strobe_oe_i,
  output logic                core_rst_o,
  output logic                core_sel_n_o,
  output logic                core_cfg_o,
  output logic                scan_mode_o,
  output wire                 scan_pad_o
);
  localparam int unsigned TAIL = NUM_PINS - 1;

  // Named internal events, visible to the bound checker.
  logic                scan_mode;
  logic                shift_evt;
  logic                capture_evt;
  logic [NUM_PINS-1:0] chain_q;
  logic                pad_drive_en;
  logic                pad_drive_val;

  scan_mode_ctl u_ctl (
    .clk           (clk),
    .rst_n         (rst_n),
    .scan_en_i     (scan_en_i),
    .dual_rst_i    (dual_rst_i),
    .dual_sel_n_i  (dual_sel_n_i),
    .dual_cfg_i    (dual_cfg_i),
    .scan_mode_o   (scan_mode),
    .shift_evt_o   (shift_evt),
    .capture_evt_o (capture_evt),
    .core_rst_o    (core_rst_o),
    .core_sel_n_o  (core_sel_n_o),
    .core_cfg_o    (core_cfg_o)
  );

  scan_cell_chain #(
    .NUM_PINS     (NUM_PINS),
    .ORDER_STRIDE (ORDER_STRIDE),
    .ORDER_OFFSET (ORDER_OFFSET),
    .RSV_PINS     (RSV_PINS)
  ) u_chain (
    .clk           (clk),
    .rst_n         (rst_n),
    .shift_evt_i   (shift_evt),
    .capture_evt_i (capture_evt),
    .probe_i       (probe_i),
    .chain_q_o     (chain_q)
  );

  scan_out_drv u_drv (
    .scan_mode_i (scan_mode),
    .tail_i      (chain_q[TAIL]),
    .scan_oe_n_i (dual_cfg_i),
    .func_data_i (func_strobe_i),
    .func_oe_i   (func_strobe_oe_i),
    .drive_en_o  (pad_drive_en),
    .drive_val_o (pad_drive_val)
  );

  assign scan_mode_o = scan_mode;
  assign scan_pad_o  = pad_drive_en ? pad_drive_val : 1'bz;
endmodule

// File: rtl/scan_chain_checker.sv
module scan_chain_checker
  import scan_pkg::*;
#(
  parameter int unsigned          NUM_PINS     = 64,
  parameter int unsigned          ORDER_STRIDE = 5,
  parameter int unsigned          ORDER_OFFSET = 3,
  parameter logic [NUM_PINS-1:0]  RSV_PINS     = 64'h0000_0100_0000_8002
) (
  input logic                clk,
  input logic                rst_n,
  input logic                scan_en_i,
  input logic                dual_cfg_i,
  input logic                scan_mode,
  input logic                shift_evt,
  input logic                capture_evt,
  input logic [NUM_PINS-1:0] chain_q,
  input logic                pad_drive_en,
  input logic                core_sel_n_o
);
  function automatic logic [NUM_PINS-1:0] rsv_positions();
    logic [NUM_PINS-1:0] m = '0;
    for (int unsigned k = 0; k < NUM_PINS; k++)
      m[k] = RSV_PINS[chain_pin(k, NUM_PINS, ORDER_STRIDE, ORDER_OFFSET)];
    return m;
  endfunction

  localparam logic [NUM_PINS-1:0] RSV_POS = rsv_positions();

  p_core_hidden_r1: assert property (@(posedge clk) disable iff (!rst_n)
    scan_mode |-> core_sel_n_o);

  p_no_entry_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (!scan_en_i && !scan_mode) |=> !scan_mode);

  p_mode_sticky_r3: assert property (@(posedge clk) disable iff (!rst_n)
    scan_mode |=> scan_mode);

  p_head_zero_r4: assert property (@(posedge clk) disable iff (!rst_n)
    shift_evt |=> !chain_q[0]);

  p_shift_step_r5: assert property (@(posedge clk) disable iff (!rst_n)
    shift_evt |=> chain_q[NUM_PINS-1] == $past(chain_q[NUM_PINS-2]));

  p_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (!shift_evt && !capture_evt) |=> $stable(chain_q));

  p_rsv_zero_r6: assert property (@(posedge clk) disable iff (!rst_n)
    capture_evt |=> (chain_q & RSV_POS) == '0);

  p_pad_off_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (scan_mode && dual_cfg_i) |-> !pad_drive_en);
endmodule

bind pin_scan_chain scan_chain_checker #(
  .NUM_PINS     (NUM_PINS),
  .ORDER_STRIDE (ORDER_STRIDE),
  .ORDER_OFFSET (ORDER_OFFSET),
  .RSV_PINS     (RSV_PINS)
) u_checker (
  .clk          (clk),
  .rst_n        (rst_n),
  .scan_en_i    (scan_en_i),
  .dual_cfg_i   (dual_cfg_i),
  .scan_mode    (scan_mode),
  .shift_evt    (shift_evt),
  .capture_evt  (capture_evt),
  .chain_q      (chain_q),
  .pad_drive_en (pad_drive_en),
  .core_sel_n_o (core_sel_n_o)
);

// File: tb/tb_pin_scan_chain.sv
module tb_pin_scan_chain;
  localparam int N = 64;
  localparam logic [N-1:0] RSV = 64'h0000_0100_0000_8002;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         scan_en = 1'b0;
  logic         d_rst = 1'b0;
  logic         d_sel_n = 1'b1;
  logic         d_cfg = 1'b0;
  logic [N-1:0] probe = '0;
  logic         f_data = 1'b0;
  logic         f_oe = 1'b0;
  logic         c_rst, c_sel_n, c_cfg, s_mode;
  wire          pad;

  pullup (pad);

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  always #5 clk = ~clk;

  pin_scan_chain dut (
    .clk              (clk),
    .rst_n            (rst_n),
    .scan_en_i        (scan_en),
    .dual_rst_i       (d_rst),
    .dual_sel_n_i     (d_sel_n),
    .dual_cfg_i       (d_cfg),
    .probe_i          (probe),
    .func_strobe_i    (f_data),
    .func_strobe_oe_i (f_oe),
    .core_rst_o       (c_rst),
    .core_sel_n_o     (c_sel_n),
    .core_cfg_o       (c_cfg),
    .scan_mode_o      (s_mode),
    .scan_pad_o       (pad)
  );

  task automatic chk(input string req, input string what, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s: actual %b expected %b", req, what, act, exp);
    end
  endtask

  // Expected content of a chain position after capturing pattern p.
  function automatic logic exp_pos(input logic [N-1:0] p, input int pos);
    int pin = (pos * 5 + 3) % N;
    return RSV[pin] ? 1'b0 : p[pin];
  endfunction

  task automatic scan_pulse(input logic shift);
    @(negedge clk); d_rst = shift; d_sel_n = 1'b0;
    @(negedge clk); d_sel_n = 1'b1;
    @(negedge clk); d_sel_n = 1'b0;
    @(negedge clk);
  endtask

  task automatic do_reset();
    rst_n = 1'b0; scan_en = 1'b0; d_sel_n = 1'b0; d_rst = 1'b0; d_cfg = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R3", "mode clear after reset", s_mode, 1'b0);
  endtask

  task automatic t_normal();
    for (int i = 0; i < 4; i++) begin
      @(negedge clk);
      d_rst = i[0]; d_sel_n = i[1]; d_cfg = ~i[0];
      f_data = i[1]; f_oe = 1'b1;
      @(negedge clk);
      chk("R2", "core_rst follows", c_rst, i[0]);
      chk("R2", "core_sel_n follows", c_sel_n, i[1]);
      chk("R2", "core_cfg follows", c_cfg, ~i[0]);
      chk("R2", "pad functional", pad, i[1]);
      chk("R2", "no scan mode", s_mode, 1'b0);
    end
    f_oe = 1'b0; f_data = 1'b0;
    @(negedge clk);
    chk("R2", "pad released (pullup)", pad, 1'b1);
  endtask

  task automatic t_enter();
    @(negedge clk); scan_en = 1'b1; d_rst = 1'b1; d_cfg = 1'b1; d_sel_n = 1'b0;
    @(negedge clk);
    chk("R1", "scan mode set", s_mode, 1'b1);
    chk("R1", "core_rst hidden", c_rst, 1'b0);
    chk("R1", "core_sel_n hidden", c_sel_n, 1'b1);
    chk("R1", "core_cfg hidden", c_cfg, 1'b0);
    d_cfg = 1'b0;
  endtask

  task automatic t_dump(input logic [N-1:0] pat, input string tag);
    probe = pat;
    scan_pulse(1'b0);
    probe = ~pat;
    // R5 hold: toggling the select without a scan-clock rise changes nothing
    d_rst = 1'b1; @(negedge clk); d_rst = 1'b0; @(negedge clk);
    chk("R5", {tag, " hold without clock"}, pad, exp_pos(pat, N - 1));
    for (int i = 0; i < N + 4; i++) begin
      if (i < N)
        chk("R8", $sformatf("%s bit %0d", tag, i), pad, exp_pos(pat, N - 1 - i));
      else
        chk("R4", $sformatf("%s trailing %0d", tag, i), pad, 1'b0);
      scan_pulse(1'b1);
    end
  endtask

  task automatic t_reserved();
    scan_pulse(1'b0);
    probe = '1;
    scan_pulse(1'b0);
    // position 12 holds pin 63, position 19 holds pin 34 (not reserved); 7 holds pin 38
    for (int i = 0; i < N; i++) begin
      if (RSV[(( N - 1 - i) * 5 + 3) % N])
        chk("R6", $sformatf("reserved slot %0d", i), pad, 1'b0);
      else if (i < 3)
        chk("R5", $sformatf("capture slot %0d", i), pad, 1'b1);
      scan_pulse(1'b1);
    end
  endtask

  task automatic t_oe();
    // chain is flushed to zero here
    d_cfg = 1'b1; @(negedge clk);
    chk("R7", "pad off when enable high", pad, 1'b1);
    d_cfg = 1'b0; @(negedge clk);
    chk("R7", "pad drives tail zero", pad, 1'b0);
  endtask

  task automatic t_sticky();
    @(negedge clk); scan_en = 1'b0; d_rst = 1'b1; d_cfg = 1'b1;
    repeat (3) @(negedge clk);
    chk("R3", "mode sticky", s_mode, 1'b1);
    chk("R3", "core_rst still hidden", c_rst, 1'b0);
    chk("R3", "core_cfg still hidden", c_cfg, 1'b0);
    d_cfg = 1'b0;
    do_reset();
    d_rst = 1'b1; @(negedge clk);
    chk("R3", "core_rst follows after reset", c_rst, 1'b1);
  endtask

  initial begin
    do_reset();
    chk("R2", "reset pad released", pad, 1'b1);
    t_normal();
    t_enter();
    t_dump(64'hA5C3_0F96_1234_FEDC, "patA");
    t_dump(64'h0F0F_3C3C_9999_6A6A, "patB");
    t_reserved();
    t_oe();
    t_sticky();
    done = 1'b1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (150000) @(posedge clk);
        fails++;
        $display("FAIL watchdog: actual timeout expected completion");
      end
    join_any
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule